// File: doc/BRIEF.md
# Bidirectional Link Direction Controller

Two neighbouring routers share one bidirectional channel, and this block decides which end may drive it at any moment. It holds two finite state machines of unequal rank, one on each end of the link. Each machine takes a channel request from its own router's route computation and the request output of the machine at the far end. From these it produces its own request output and a transmit enable that lets its side drive the wires.

The high-rank end starts out owning the channel. It hands the channel over only when it has nothing to send and the far end is asking. It takes the channel back after a short two-cycle wait. The low-rank end starts out receiving. It must wait four quiet cycles before it may transmit, it gives up the attempt as soon as the high-rank end asks, and it is cut off at once while transmitting if the high-rank end asks. Both wait lengths are parameters. The top module connects the two machines back to back, as two adjacent routers would be connected.

Top module: `ldc_link_pair`

## Requirements
- R1: After reset the high-rank state is FREE and the low-rank state is IDLE. The state outputs use the encoding IDLE=0, WAIT=1, FREE=2.
- R2: In FREE the high-rank request output equals its channel request. The high-rank machine leaves FREE, going to IDLE, only when its channel request is 0 and the low-rank request output is 1.
- R3: In IDLE the high-rank request output is 0 and the machine stays in IDLE while its channel request is 0. A channel request of 1 moves it to WAIT on the next cycle.
- R4: In WAIT the high-rank request output is 1. The machine spends exactly HI_WAIT (default 2) cycles there and then enters FREE, whatever the inputs are.
- R5: In IDLE the low-rank request output is 0. The low-rank machine moves to WAIT only when its channel request is 1 and the high-rank request output is 0.
- R6: In WAIT the low-rank request output is 1. A high-rank request output of 1 in any WAIT cycle sends it to IDLE on the next cycle.
- R7: The low-rank machine enters FREE only after LO_WAIT (default 4) consecutive WAIT cycles in which the high-rank request was 0. An aborted wait restarts from zero.
- R8: In FREE the low-rank request output is 1. When the high-rank request output is 1, the low-rank transmit enable drops in that same cycle and the state becomes IDLE on the next cycle.
- R9: A transmit enable is 1 only in FREE. The two enables are never 1 together, and the two machines are never both in FREE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_chan_req | input | 1 | High-rank end has flits for the channel |
| lo_chan_req | input | 1 | Low-rank end has flits for the channel |
| hi_out_req | output | 1 | High-rank request toward the low-rank end |
| lo_out_req | output | 1 | Low-rank request toward the high-rank end |
| hi_tx_en | output | 1 | High-rank end may drive the channel |
| lo_tx_en | output | 1 | Low-rank end may drive the channel |
| hi_state | output | 2 | High-rank state (IDLE=0, WAIT=1, FREE=2) |
| lo_state | output | 2 | Low-rank state (IDLE=0, WAIT=1, FREE=2) |

## Verification
The assertions check the following on every cycle: mutual exclusion of the two enables and of the two FREE states, the hold and exit conditions of each state, the same-cycle cut-off of the low-rank enable, and, through counters in the checker, that every entry to FREE from WAIT follows exactly the configured number of wait cycles. Some behaviour only the bench scenarios can show. One case is an aborted low-rank wait that later restarts and completes. Another is the high-rank end taking the channel back while the low-rank end is transmitting. A third is long mixed request patterns in which the two ends hand the channel back and forth. The bench follows all of these with its own cycle-level model.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

  typedef enum logic [1:0] {
    LDC_IDLE = 2'd0,
    LDC_WAIT = 2'd1,
    LDC_FREE = 2'd2
  } ldc_state_e;

  // High-rank next state: yields only when idle locally and asked remotely.
  function automatic ldc_state_e hp_next(ldc_state_e s, logic creq,
                                         logic ireq, logic done);
    ldc_state_e n;
    n = s;
    unique case (s)
      LDC_FREE: if (!creq && ireq) n = LDC_IDLE;
      LDC_IDLE: if (creq) n = LDC_WAIT;
      LDC_WAIT: if (done) n = LDC_FREE;
      default:  n = LDC_FREE;
    endcase
    return n;
  endfunction

  // Low-rank next state: any remote request wins over a wait or a transfer.
  function automatic ldc_state_e lp_next(ldc_state_e s, logic creq,
                                         logic ireq, logic done);
    ldc_state_e n;
    n = s;
    unique case (s)
      LDC_IDLE: if (creq && !ireq) n = LDC_WAIT;
      LDC_WAIT: begin
        if (ireq)      n = LDC_IDLE;
        else if (done) n = LDC_FREE;
      end
      LDC_FREE: if (ireq) n = LDC_IDLE;
      default:  n = LDC_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic hp_req(ldc_state_e s, logic creq);
    return (s == LDC_WAIT) || ((s == LDC_FREE) && creq);
  endfunction

  function automatic logic lp_req(ldc_state_e s);
    return (s == LDC_WAIT) || (s == LDC_FREE);
  endfunction

endpackage

// File: rtl/ldc_wait_timer.sv
module ldc_wait_timer #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic abort,
  output logic hit
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign hit = run && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (!run || abort || hit) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ldc_side.sv
module ldc_side
  import ldc_pkg::*;
#(
  parameter bit          HIGH_PRI    = 1'b1,
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_req,
  input  logic       in_req,
  output logic       out_req,
  output logic       tx_en,
  output ldc_state_e state_o
);
  localparam ldc_state_e RST_STATE = HIGH_PRI ? LDC_FREE : LDC_IDLE;

  ldc_state_e state_q, state_d;
  logic       in_wait;
  logic       wait_done;
  logic       wait_abort;

  assign in_wait = (state_q == LDC_WAIT);

  ldc_wait_timer #(.LIMIT(WAIT_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_wait),
    .abort (wait_abort),
    .hit   (wait_done)
  );

  generate
    if (HIGH_PRI) begin : g_high
      assign wait_abort = 1'b0;
      always_comb begin
        state_d = hp_next(state_q, chan_req, in_req, wait_done);
        out_req = hp_req(state_q, chan_req);
        tx_en   = (state_q == LDC_FREE);
      end
    end else begin : g_low
      assign wait_abort = in_wait && in_req;
      always_comb begin
        state_d = lp_next(state_q, chan_req, in_req, wait_done);
        out_req = lp_req(state_q);
        tx_en   = (state_q == LDC_FREE) && !in_req;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RST_STATE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ldc_link_pair.sv
module ldc_link_pair
  import ldc_pkg::*;
#(
  parameter int unsigned HI_WAIT = 2,
  parameter int unsigned LO_WAIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hi_chan_req,
  input  logic       lo_chan_req,
  output logic       hi_out_req,
  output logic       lo_out_req,
  output logic       hi_tx_en,
  output logic       lo_tx_en,
  output logic [1:0] hi_state,
  output logic [1:0] lo_state
);
  ldc_state_e hi_st, lo_st;

  ldc_side #(.HIGH_PRI(1'b1), .WAIT_CYCLES(HI_WAIT)) u_hi (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_req (hi_chan_req),
    .in_req   (lo_out_req),
    .out_req  (hi_out_req),
    .tx_en    (hi_tx_en),
    .state_o  (hi_st)
  );

  ldc_side #(.HIGH_PRI(1'b0), .WAIT_CYCLES(LO_WAIT)) u_lo (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_req (lo_chan_req),
    .in_req   (hi_out_req),
    .out_req  (lo_out_req),
    .tx_en    (lo_tx_en),
    .state_o  (lo_st)
  );

  assign hi_state = hi_st;
  assign lo_state = lo_st;
endmodule

// File: rtl/ldc_link_pair_chk.sv
module ldc_link_pair_chk #(
  parameter int unsigned HI_WAIT = 2,
  parameter int unsigned LO_WAIT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hi_chan_req,
  input logic       lo_chan_req,
  input logic       hi_out_req,
  input logic       lo_out_req,
  input logic       hi_tx_en,
  input logic       lo_tx_en,
  input logic [1:0] hi_state,
  input logic [1:0] lo_state
);
  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_WAIT = 2'd1;
  localparam logic [1:0] S_FREE = 2'd2;

  int unsigned hi_run, lo_run;
  logic        hi_prev_wait, lo_prev_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= 0; lo_run <= 0; hi_prev_wait <= 1'b0; lo_prev_wait <= 1'b0;
    end else begin
      hi_run       <= (hi_state == S_WAIT) ? hi_run + 1 : 0;
      lo_run       <= (lo_state == S_WAIT) ? lo_run + 1 : 0;
      hi_prev_wait <= (hi_state == S_WAIT);
      lo_prev_wait <= (lo_state == S_WAIT);
    end
  end

  assert_hi_free_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_state == S_FREE && (hi_chan_req || !lo_out_req)) |=> hi_state == S_FREE);

  assert_hi_idle_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_state == S_IDLE && hi_chan_req) |=> hi_state == S_WAIT);

  assert_hi_wait_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hi_state == S_WAIT |-> hi_run < HI_WAIT);

  assert_hi_wait_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_state == S_FREE && hi_prev_wait) |-> hi_run == HI_WAIT);

  assert_lo_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_state == S_IDLE && (hi_out_req || !lo_chan_req)) |=> lo_state == S_IDLE);

  assert_lo_wait_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_state == S_WAIT && hi_out_req) |=> lo_state == S_IDLE);

  assert_lo_wait_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_state == S_FREE && lo_prev_wait) |-> lo_run == LO_WAIT);

  assert_lo_cut_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_state == S_FREE && hi_out_req) |-> !lo_tx_en);

  assert_lo_cut_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_state == S_FREE && hi_out_req) |=> lo_state == S_IDLE);

  assert_tx_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_tx_en && lo_tx_en));

  assert_free_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_state == S_FREE && lo_state == S_FREE));

  assert_tx_only_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_tx_en -> hi_state == S_FREE) && (lo_tx_en -> lo_state == S_FREE));
endmodule

bind ldc_link_pair ldc_link_pair_chk #(.HI_WAIT(HI_WAIT), .LO_WAIT(LO_WAIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hi_chan_req (hi_chan_req),
  .lo_chan_req (lo_chan_req),
  .hi_out_req  (hi_out_req),
  .lo_out_req  (lo_out_req),
  .hi_tx_en    (hi_tx_en),
  .lo_tx_en    (lo_tx_en),
  .hi_state    (hi_state),
  .lo_state    (lo_state)
);

// File: tb/ldc_link_pair_tb.sv
`timescale 1ns/1ps
module ldc_link_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hc = 1'b0, lc = 1'b0;
  logic       hi_out_req, lo_out_req, hi_tx_en, lo_tx_en;
  logic [1:0] hi_state, lo_state;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  ldc_link_pair dut_i (
    .clk(clk), .rst_n(rst_n), .hi_chan_req(hc), .lo_chan_req(lc),
    .hi_out_req(hi_out_req), .lo_out_req(lo_out_req),
    .hi_tx_en(hi_tx_en), .lo_tx_en(lo_tx_en),
    .hi_state(hi_state), .lo_state(lo_state)
  );

  // bench model; encoding IDLE=0 WAIT=1 FREE=2
  int    m_hs = 2, m_ls = 0, m_hw = 0, m_lw = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  string      cur_tag = "R1";

  function automatic logic [7:0] pack(int hs, int ls, logic ho, logic lo,
                                      logic ht, logic lt);
    return {hs[1:0], ls[1:0], ho, lo, ht, lt};
  endfunction

  task automatic step(input logic h, input logic l);
    logic ho, lo, ht, lt;
    @(negedge clk);
    hc = h; lc = l;
    ho = (m_hs == 1) ? 1'b1 : ((m_hs == 2) ? h : 1'b0);
    lo = (m_ls != 0);
    ht = (m_hs == 2);
    lt = (m_ls == 2) && !ho;
    exp_q.push_back(pack(m_hs, m_ls, ho, lo, ht, lt));
    tag_q.push_back(cur_tag);
    // advance model by one clock
    case (m_hs)
      2: if (!h && lo) m_hs = 0;
      0: if (h) begin m_hs = 1; m_hw = 0; end
      default: begin m_hw++; if (m_hw == 2) m_hs = 2; end
    endcase
    case (m_ls)
      0: if (l && !ho) begin m_ls = 1; m_lw = 0; end
      1: if (ho) m_ls = 0; else begin m_lw++; if (m_lw == 4) m_ls = 2; end
      default: if (ho) m_ls = 0;
    endcase
  endtask

  task automatic run(input logic h, input logic l, input int n);
    for (int i = 0; i < n; i++) step(h, l);
  endtask

  // monitor: compares DUT outputs mid-cycle against queued expectations
  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [7:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {hi_state, lo_state, hi_out_req, lo_out_req, hi_tx_en, lo_tx_en};
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: {hs,ls,ho,lo,ht,lt} actual %b expected %b at %0t", t, a, e, $time);
      end
      n_cmp++;
      if (hi_tx_en && lo_tx_en) begin
        n_bad++;
        $display("FAIL R9: both enables high, actual 11 expected not 11 at %0t", $time);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #2;
    n_cmp++;  // R1 reset state check
    if (hi_state !== 2'd2 || lo_state !== 2'd0) begin
      n_bad++;
      $display("FAIL R1: states actual %0d/%0d expected 2/0", hi_state, lo_state);
    end
    @(negedge clk); rst_n = 1'b1;
    cur_tag = "R1"; run(0, 0, 2);
    cur_tag = "R2"; run(1, 0, 3); run(0, 0, 2);
    cur_tag = "R5"; run(1, 1, 3);
    cur_tag = "R7"; run(0, 1, 7);
    cur_tag = "R3"; run(0, 0, 3); run(0, 1, 2);
    cur_tag = "R8"; run(1, 1, 1);
    cur_tag = "R4"; run(1, 1, 4);
    cur_tag = "R6"; run(0, 1, 3); run(1, 1, 1); run(0, 1, 3);
    cur_tag = "R7"; run(0, 1, 8);
    cur_tag = "R8"; run(1, 0, 5);
    cur_tag = "R9";
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3] & lfsr[7], lfsr[1] | lfsr[9]);
    end
    run(0, 0, 2);
    @(negedge clk); @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1;
    $finish;
  end
endmodule